// File: doc/BRIEF.md
# Vertex Property Atomic Reduce Unit

This unit takes a stream of updates, each a destination vertex number and a 32-bit value, and folds every update into a temporary-property array. The array lives in an on-chip scratchpad with one read port and one write port. Each update passes through three registered steps. First the stored property is read. Then it is combined with the incoming value by the selected reduce function. Finally the result is written back. A static configuration input selects the reduce function: unsigned minimum for traversal and shortest-path distances, or wrapping integer sum for rank accumulation.

Updates enter through a small queue with a valid/ready handshake. A vertex that is already being read or reduced must not be read again before its new value is written. When the update at the head of the queue names such a vertex, the head waits. Issue for that vertex resumes in the cycle after the matching write. No value is forwarded between updates. When no two nearby updates share a vertex, the unit starts one update per cycle.

Before an iteration starts, a fill sweep writes one programmable value into every scratchpad entry. Issue of updates is held off during the sweep. An `idle` output reports that the queue, the pipeline and the sweep are all empty.

Top module: `vtx_accum_rmw`

## Requirements
- R1: With `cfg_op`=0, the property stored after an update is the unsigned minimum of the old property and the update value.
- R2: With `cfg_op`=1, the property stored after an update is the old property plus the update value, modulo 2^32.
- R3: An isolated update accepted on a clock edge produces a scratchpad read request for its vertex in the following cycle. The write to the same address follows two cycles after that read request. No write occurs in the cycle between them.
- R4: Several updates to the same vertex, offered back to back, are all applied. None of them is lost.
- R5: No read request is made for a vertex while an earlier update to that vertex is in its read or reduce step. The second of two back-to-back updates to one vertex issues its read three cycles after the first one does, which is the cycle after the first one's write.
- R6: Updates to distinct vertices issue their read requests in consecutive cycles, one per cycle.
- R7: The input queue holds `FIFO_DEPTH` (default 4) updates. `in_ready` is low while the queue is full, and updates waiting in a full queue are applied later without loss.
- R8: A one-cycle `init_start` pulse, given while the pipeline is empty, writes `init_value` to every scratchpad address from 0 upward, one address per cycle. No read request is made until the sweep ends.
- R9: `idle` is high only when the queue, the pipeline stages and the fill sweep are all empty. It is low while an accepted update is still pending.
- R10: After reset, `idle` and `in_ready` are high and neither scratchpad port is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op | input | 1 | Reduce select: 0 unsigned minimum, 1 wrapping sum |
| init_start | input | 1 | Pulse that starts the fill sweep |
| init_value | input | 32 | Value written by the fill sweep |
| in_valid | input | 1 | Update offered |
| in_ready | output | 1 | Queue can accept an update |
| in_vid | input | VID_W | Destination vertex of the update |
| in_val | input | 32 | Update value |
| sp_rd_en | output | 1 | Scratchpad read request |
| sp_rd_addr | output | VID_W | Scratchpad read address |
| sp_rd_data | input | 32 | Read data, valid one cycle after the request |
| sp_wr_en | output | 1 | Scratchpad write request |
| sp_wr_addr | output | VID_W | Scratchpad write address |
| sp_wr_data | output | 32 | Scratchpad write data |
| idle | output | 1 | No queued, in-flight or sweep work |

## Verification
The bench models the scratchpad with read-before-write behaviour. With that model, a unit that let a second update to one vertex issue early would read the stale value, and one of the two contributions would vanish from the final sum. Cycle-exact read and write patterns for same-vertex pairs and for distinct-vertex bursts show whether the stall is too short, which loses updates, or too long or global, which costs throughput. The sum phase includes a value that wraps past 2^32, so an adder that saturates or widens would give the wrong result. The queue is filled while the sweep holds issue, so a queue that dropped or overwrote entries would leave some vertices at the fill value.

// File: rtl/vtx_accum_pkg.sv
package vtx_accum_pkg;

  localparam int unsigned PROP_W = 32;

  typedef logic [PROP_W-1:0] prop_t;

  typedef enum logic {
    RED_MIN = 1'b0,
    RED_ADD = 1'b1
  } red_op_e;

  // Combine the stored property with an incoming update value.
  function automatic prop_t reduce_prop(red_op_e op, prop_t cur, prop_t upd);
    prop_t r;
    if (op == RED_ADD) r = cur + upd;
    else               r = (upd < cur) ? upd : cur;
    return r;
  endfunction

endpackage

// File: rtl/vtx_accum_fifo.sv
module vtx_accum_fifo #(
  parameter int unsigned W     = 38,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) slot[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full)  wr_ptr <= bump(wr_ptr);
      if (pop && !empty)  rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/vtx_accum_init.sv
module vtx_accum_init #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
    end else if (busy) begin
      addr <= addr + 1'b1;
      if (addr == LAST) busy <= 1'b0;
    end else if (go) begin
      busy <= 1'b1;
      addr <= '0;
    end
  end

  // R8
  init_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> addr == AW'($past(addr) + 1'b1));

  // R8
  init_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> addr == '0);

endmodule

// File: rtl/vtx_accum_pipe.sv
module vtx_accum_pipe
  import vtx_accum_pkg::*;
#(
  parameter int unsigned VID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  red_op_e          op,
  input  logic             head_valid,
  input  logic [VID_W-1:0] head_vid,
  input  prop_t            head_val,
  input  logic             block,
  output logic             issue,
  output logic             rd_en,
  output logic [VID_W-1:0] rd_addr,
  input  prop_t            rd_data,
  output logic             wb_valid,
  output logic [VID_W-1:0] wb_vid,
  output prop_t            wb_data,
  output logic             busy
);
  localparam int unsigned NSTG = 2;

  logic             rd_v;
  logic [VID_W-1:0] rd_vid;
  prop_t            rd_val;

  logic [NSTG-1:0]  stg_v;
  logic [VID_W-1:0] stg_vid [NSTG];
  logic [NSTG-1:0]  stg_hit;
  logic             hazard;

  assign stg_v      = {wb_valid, rd_v};
  assign stg_vid[0] = rd_vid;
  assign stg_vid[1] = wb_vid;

  for (genvar g = 0; g < NSTG; g++) begin : g_cmp
    assign stg_hit[g] = stg_v[g] && (stg_vid[g] == head_vid);
  end

  assign hazard  = |stg_hit;
  assign issue   = head_valid && !block && !hazard;
  assign rd_en   = issue;
  assign rd_addr = head_vid;
  assign busy    = rd_v || wb_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_v     <= 1'b0;
      wb_valid <= 1'b0;
    end else begin
      rd_v     <= issue;
      wb_valid <= rd_v;
    end
  end

  always_ff @(posedge clk) begin
    rd_vid  <= head_vid;
    rd_val  <= head_val;
    wb_vid  <= rd_vid;
    wb_data <= reduce_prop(op, rd_data, rd_val);
  end

  // R5
  rw_same_vertex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wb_valid) |-> rd_addr != wb_vid);

  // R5
  inflight_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_v) |-> rd_addr != rd_vid);

  // R3
  stage_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |=> (wb_valid && wb_vid == $past(rd_vid)));

  // R8
  init_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !rd_en);

endmodule

// File: rtl/vtx_accum_rmw.sv
module vtx_accum_rmw
  import vtx_accum_pkg::*;
#(
  parameter int unsigned VID_W      = 6,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_op,
  input  logic             init_start,
  input  logic [31:0]      init_value,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VID_W-1:0] in_vid,
  input  logic [31:0]      in_val,
  output logic             sp_rd_en,
  output logic [VID_W-1:0] sp_rd_addr,
  input  logic [31:0]      sp_rd_data,
  output logic             sp_wr_en,
  output logic [VID_W-1:0] sp_wr_addr,
  output logic [31:0]      sp_wr_data,
  output logic             idle
);
  localparam int unsigned ENT_W = VID_W + PROP_W;

  logic             q_full, q_empty, q_pop;
  logic [ENT_W-1:0] q_dout;
  logic             init_busy, init_go;
  logic [VID_W-1:0] init_addr;
  logic             pipe_busy;
  logic             wb_valid;
  logic [VID_W-1:0] wb_vid;
  prop_t            wb_data;

  assign in_ready = !q_full;

  vtx_accum_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .din   ({in_vid, in_val}),
    .full  (q_full),
    .pop   (q_pop),
    .dout  (q_dout),
    .empty (q_empty)
  );

  assign init_go = init_start && !pipe_busy && !init_busy;

  vtx_accum_init #(.AW(VID_W)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (init_go),
    .busy  (init_busy),
    .addr  (init_addr)
  );

  vtx_accum_pipe #(.VID_W(VID_W)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (red_op_e'(cfg_op)),
    .head_valid (!q_empty),
    .head_vid   (q_dout[ENT_W-1:PROP_W]),
    .head_val   (q_dout[PROP_W-1:0]),
    .block      (init_busy),
    .issue      (q_pop),
    .rd_en      (sp_rd_en),
    .rd_addr    (sp_rd_addr),
    .rd_data    (sp_rd_data),
    .wb_valid   (wb_valid),
    .wb_vid     (wb_vid),
    .wb_data    (wb_data),
    .busy       (pipe_busy)
  );

  assign sp_wr_en   = init_busy || wb_valid;
  assign sp_wr_addr = init_busy ? init_addr  : wb_vid;
  assign sp_wr_data = init_busy ? init_value : wb_data;

  assign idle = q_empty && !pipe_busy && !init_busy;

  // R8
  init_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> !wb_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!sp_wr_en && !sp_rd_en));

  // R9
  accept_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !idle);

endmodule

// File: tb/vtx_accum_rmw_bench.sv
`timescale 1ns/1ps
module vtx_accum_rmw_bench;
  localparam int VID_W = 6;
  localparam int DEPTH = 1 << VID_W;
  localparam int NVEC  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cfg_op = 1'b1;
  logic             init_start = 1'b0;
  logic [31:0]      init_value = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [VID_W-1:0] in_vid = '0;
  logic [31:0]      in_val = '0;
  logic             sp_rd_en, sp_wr_en, idle;
  logic [VID_W-1:0] sp_rd_addr, sp_wr_addr;
  logic [31:0]      sp_rd_data, sp_wr_data;

  vtx_accum_rmw #(.VID_W(VID_W), .FIFO_DEPTH(4)) u_vtx_accum_rmw (
    .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .init_start(init_start),
    .init_value(init_value), .in_valid(in_valid), .in_ready(in_ready),
    .in_vid(in_vid), .in_val(in_val), .sp_rd_en(sp_rd_en),
    .sp_rd_addr(sp_rd_addr), .sp_rd_data(sp_rd_data), .sp_wr_en(sp_wr_en),
    .sp_wr_addr(sp_wr_addr), .sp_wr_data(sp_wr_data), .idle(idle)
  );

  // Scratchpad model: registered read returning the old contents.
  logic [31:0] mem [DEPTH];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 32'hA500_0000 + i;
    end else begin
      if (sp_wr_en) mem[sp_wr_addr] <= sp_wr_data;
      if (sp_rd_en) sp_rd_data <= mem[sp_rd_addr];
    end
  end

  // {vid, value}: repeats on purpose; vid 5 wraps in sum mode.
  localparam logic [37:0] VEC [NVEC] = '{
    {6'd3, 32'd10}, {6'd3, 32'd7}, {6'd5, 32'hFFFF_FFF0}, {6'd5, 32'h20},
    {6'd9, 32'd100}, {6'd3, 32'd2}, {6'd12, 32'd50}, {6'd9, 32'd1},
    {6'd12, 32'd49}, {6'd63, 32'd8}, {6'd0, 32'd4}, {6'd63, 32'd3},
    {6'd0, 32'd9}, {6'd5, 32'd5}, {6'd7, 32'd77}, {6'd7, 32'd76}
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] expv [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [VID_W-1:0] v, input logic [31:0] d);
    in_valid = 1'b1; in_vid = v; in_val = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!idle) @(negedge clk);
  endtask

  task automatic do_init(input logic [31:0] v);
    init_value = v;
    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    for (int i = 0; i < DEPTH; i++) expv[i] = v;
  endtask

  function automatic logic [31:0] model(input bit add, input logic [31:0] a, input logic [31:0] b);
    if (add) return a + b;
    return (a < b) ? a : b;
  endfunction

  task automatic run_table(input bit add, input string req);
    cfg_op = add;
    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][37:32], VEC[i][31:0]);
      expv[VEC[i][37:32]] = model(add, expv[VEC[i][37:32]], VEC[i][31:0]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    wait_idle();
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) chk(mem[a] == expv[a], req, mem[a], expv[a]);
  endtask

  initial begin
    logic [7:0] rdpat, wrpat;
    logic [31:0] e30;
    int bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(idle == 1'b1, "R10 idle", idle, 1);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    chk(!sp_rd_en && !sp_wr_en, "R10 ports quiet", {sp_rd_en, sp_wr_en}, 0);

    // R8 fill sweep
    do_init(32'h0000_0000);
    chk(!sp_rd_en && sp_wr_en && sp_wr_addr == 0, "R8 sweep starts at 0", sp_wr_addr, 0);
    wait_idle();
    bad = 0;
    for (int a = 0; a < DEPTH; a++) if (mem[a] != 0) bad++;
    chk(bad == 0, "R8 every entry filled", bad, 0);

    // R2 and R4: sum phase through the vector table
    run_table(1'b1, "R2 sum table");
    chk(mem[5] == 32'h15, "R2 wrap at vid 5", mem[5], 32'h15);
    chk(mem[3] == 32'd19, "R4 three updates to vid 3", mem[3], 19);

    // R3 isolated update timing, R9 idle low while pending
    in_valid = 1'b1; in_vid = 6'd20; in_val = 32'd1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(sp_rd_en && sp_rd_addr == 6'd20, "R3 read next cycle", {31'd0, sp_rd_en}, 1);
    chk(idle == 1'b0, "R9 idle low while pending", idle, 0);
    @(negedge clk);
    chk(!sp_wr_en, "R3 no write in middle cycle", sp_wr_en, 0);
    @(negedge clk);
    chk(sp_wr_en && sp_wr_addr == 6'd20 && sp_wr_data == 32'd1, "R3 write two after read", sp_wr_data, 1);
    wait_idle();

    // R5 same vertex back to back
    e30 = mem[30] + 32'd3 + 32'd4;
    rdpat = '0; wrpat = '0;
    for (int i = 0; i < 8; i++) begin
      rdpat[i] = sp_rd_en && sp_rd_addr == 6'd30;
      wrpat[i] = sp_wr_en && sp_wr_addr == 6'd30;
      in_valid = (i < 2); in_vid = 6'd30; in_val = (i == 0) ? 32'd3 : 32'd4;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(rdpat == 8'b0001_0010, "R5 read spacing", rdpat, 8'b0001_0010);
    chk(wrpat == 8'b0100_1000, "R5 write spacing", wrpat, 8'b0100_1000);
    wait_idle();
    chk(mem[30] == e30, "R4 pair not lost", mem[30], e30);

    // R6 distinct vertices one per cycle
    rdpat = '0;
    for (int i = 0; i < 8; i++) begin
      rdpat[i] = sp_rd_en;
      in_valid = (i < 4); in_vid = VID_W'(40 + i); in_val = 32'd1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(rdpat == 8'b0001_1110, "R6 back-to-back reads", rdpat, 8'b0001_1110);
    wait_idle();

    // R1 minimum phase through the vector table
    do_init(32'hFFFF_FF00);
    wait_idle();
    run_table(1'b0, "R1 min table");

    // R7 queue fills while the sweep holds issue
    do_init(32'h0000_1000);
    push(6'd50, 32'h0800);
    push(6'd51, 32'h2000);
    push(6'd52, 32'h0001);
    push(6'd53, 32'h1000);
    chk(in_ready == 1'b0, "R7 ready low when full", in_ready, 0);
    chk(sp_rd_en == 1'b0, "R8 no read during sweep", sp_rd_en, 0);
    push(6'd54, 32'h0FFF);
    in_valid = 1'b0;
    @(negedge clk);
    wait_idle();
    @(negedge clk);
    chk(mem[50] == 32'h0800, "R7 entry 50", mem[50], 32'h0800);
    chk(mem[51] == 32'h1000, "R7 entry 51", mem[51], 32'h1000);
    chk(mem[52] == 32'h0001, "R7 entry 52", mem[52], 32'h0001);
    chk(mem[54] == 32'h0FFF, "R7 queued fifth", mem[54], 32'h0FFF);
    chk(idle == 1'b1, "R9 idle when drained", idle, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule